// File: doc/BRIEF.md
# Graphic Display RAM Host Port

This block sits between an 8-bit parallel microcontroller bus and the byte-wide memory that holds a graphic panel's pixel bits. A host cycle is framed by an enable strobe. While the strobe is high and every chip select is active, two lines classify the cycle. A data/instruction select picks between pixel data and control. A read/write line gives the direction. Writes take effect when the strobe falls. Reads drive the returned byte only while the strobe is high.

The memory address has two parts. A page number chooses one of eight horizontal bands. It is a plain register that only an instruction can load. A 6-bit column counter chooses the byte within the page. An instruction loads it, and it moves forward by one after every pixel-data access, wrapping from 63 to 0 inside the same page. Instructions also switch the display on or off and choose which memory line is shown at the top of the panel. A status read reports the display state and whether a host-side reset is in progress. A scan-out engine downstream consumes the display-on flag and the start line.

Top module: `gdram_host_if`

## Requirements
- R1: After the block reset, the display-on flag is 0, the start line is 0, the page and column are 0, and a status read returns 0x20.
- R2: A data write (select=1, read/write=0) stores the byte at address {page, column} when the strobe falls, and the column then advances by one.
- R3: The column counter wraps from 63 to 0. Further data accesses continue in the same page.
- R4: The page never counts. It changes only on the instruction 10111ppp, which loads ppp.
- R5: A data read (select=1, read/write=1) returns the byte at {page, column} while the strobe is high, and the column advances by one when the strobe falls.
- R6: A status read (select=0, read/write=1) returns bit 5 = 1 when the display is off, bit 4 = 1 during host reset, and all other bits 0.
- R7: Instruction 0011111d sets the display-on flag to d and leaves the memory contents unchanged.
- R8: Instruction 11ssssss loads the start line with ssssss. Instruction 01cccccc loads the column with cccccc.
- R9: A cycle with any chip select low is ignored. It writes nothing, changes no register, and leaves the bus undriven.
- R10: The bus is driven only while the strobe is high, all selects are active and read/write is 1. Register and memory updates happen only on a strobe fall.
- R11: While the host reset input is high, the display-on flag and the start line are held at 0, instructions and data accesses are ignored, and status bit 4 reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| host_rst | input | 1 | Host-side reset request, active high |
| bus_en | input | 1 | Cycle enable strobe |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_di | input | 1 | 1 = pixel data, 0 = instruction/status |
| bus_cs | input | NUM_CS | Chip selects, all must be 1 |
| db_in | input | 8 | Byte from host |
| db_out | output | 8 | Byte to host |
| db_oe | output | 1 | Host bus drive enable |
| disp_on | output | 1 | Display-on flag for scan-out |
| start_line | output | COL_W | Top displayed line for scan-out |

## Verification
The bench uses the default parameters: three chip selects, eight pages of 64 columns, and the registered read path. With this geometry, a short sequence of three writes crosses the 63-to-0 column wrap. The bench then confirms that the neighbouring page's byte is untouched, which shows that the page did not count. With three selects, a cycle that has only one select low can be tested against the all-active case.

// File: rtl/gdram_pkg.sv
package gdram_pkg;
   typedef enum logic [2:0] {
      OP_NONE,
      OP_ONOFF,
      OP_START,
      OP_PAGE,
      OP_COL
   } op_e;

   localparam int STAT_OFF_BIT = 5;
   localparam int STAT_RST_BIT = 4;

   function automatic op_e decode_op(input logic [7:0] b);
      if (b[7:1] == 7'b0011111)      return OP_ONOFF;
      else if (b[7:6] == 2'b11)      return OP_START;
      else if (b[7:3] == 5'b10111)   return OP_PAGE;
      else if (b[7:6] == 2'b01)      return OP_COL;
      else                           return OP_NONE;
   endfunction
endpackage

// File: rtl/gdram_strobe.sv
module gdram_strobe #(
   parameter int DATA_W = 8,
   parameter int NUM_CS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_rd,
   input  logic              bus_di,
   input  logic [NUM_CS-1:0] bus_cs,
   input  logic [DATA_W-1:0] db_in,
   output logic              commit,
   output logic              cap_rd,
   output logic              cap_di,
   output logic [DATA_W-1:0] cap_data
);
   logic en_d;
   logic cap_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d     <= 1'b0;
         cap_sel  <= 1'b0;
         cap_rd   <= 1'b0;
         cap_di   <= 1'b0;
         cap_data <= '0;
      end else begin
         en_d <= bus_en;
         if (bus_en) begin
            cap_sel  <= &bus_cs;
            cap_rd   <= bus_rd;
            cap_di   <= bus_di;
            cap_data <= db_in;
         end
      end
   end

   assign commit = en_d & ~bus_en & cap_sel;

   a_r10_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ($past(bus_en) && !bus_en));
endmodule

// File: rtl/gdram_regs.sv
module gdram_regs
   import gdram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 3,
   parameter int COL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rst,
   input  logic              commit,
   input  logic              cap_rd,
   input  logic              cap_di,
   input  logic [DATA_W-1:0] cap_data,
   output logic              ram_we,
   output logic [PAGE_W-1:0] page,
   output logic [COL_W-1:0]  col,
   output logic [COL_W-1:0]  start_line,
   output logic              disp_on
);
   localparam logic [COL_W-1:0] COL_LAST = {COL_W{1'b1}};

   logic live, data_acc, instr_wr;
   op_e  op;

   assign live     = commit & ~host_rst;
   assign data_acc = live & cap_di;
   assign instr_wr = live & ~cap_di & ~cap_rd;
   assign ram_we   = data_acc & ~cap_rd;
   assign op       = decode_op(cap_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page       <= '0;
         col        <= '0;
         start_line <= '0;
         disp_on    <= 1'b0;
      end else if (host_rst) begin
         start_line <= '0;
         disp_on    <= 1'b0;
      end else if (data_acc) begin
         col <= col + 1'b1;
      end else if (instr_wr) begin
         case (op)
            OP_ONOFF: disp_on    <= cap_data[0];
            OP_START: start_line <= cap_data[COL_W-1:0];
            OP_PAGE:  page       <= cap_data[PAGE_W-1:0];
            OP_COL:   col        <= cap_data[COL_W-1:0];
            default:  ;
         endcase
      end
   end

   a_r3_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && col == COL_LAST) |=> (col == '0));
   a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && col != COL_LAST) |=> (col == $past(col) + 1'b1));
   a_r4_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_wr && op == OP_PAGE) |=> $stable(page));
   a_r11_rst_clear: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst |=> (!disp_on && start_line == '0));
endmodule

// File: rtl/gdram_mem.sv
module gdram_mem #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 9,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) rdata <= mem[addr];
      end else begin : g_rd_comb
         assign rdata = mem[addr];
      end
   endgenerate
endmodule

// File: rtl/gdram_host_if.sv
module gdram_host_if
   import gdram_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PAGE_W   = 3,
   parameter int COL_W    = 6,
   parameter int NUM_CS   = 3,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rst,
   input  logic              bus_en,
   input  logic              bus_rd,
   input  logic              bus_di,
   input  logic [NUM_CS-1:0] bus_cs,
   input  logic [DATA_W-1:0] db_in,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe,
   output logic              disp_on,
   output logic [COL_W-1:0]  start_line
);
   localparam int ADDR_W = PAGE_W + COL_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("gdram_host_if: opcode layout needs DATA_W == 8");
      end
      if (COL_W != 6 || PAGE_W < 1 || PAGE_W > 3) begin : g_bad_geom
         $error("gdram_host_if: needs COL_W == 6 and PAGE_W in 1..3");
      end
      if (NUM_CS < 1) begin : g_bad_cs
         $error("gdram_host_if: needs at least one chip select");
      end
   endgenerate

   logic              commit, cap_rd, cap_di, ram_we;
   logic [DATA_W-1:0] cap_data, ram_q, status;
   logic [PAGE_W-1:0] page;
   logic [COL_W-1:0]  col;

   gdram_strobe #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_strobe (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rd(bus_rd),
      .bus_di(bus_di), .bus_cs(bus_cs), .db_in(db_in), .commit(commit),
      .cap_rd(cap_rd), .cap_di(cap_di), .cap_data(cap_data)
   );

   gdram_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .COL_W(COL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .commit(commit),
      .cap_rd(cap_rd), .cap_di(cap_di), .cap_data(cap_data),
      .ram_we(ram_we), .page(page), .col(col),
      .start_line(start_line), .disp_on(disp_on)
   );

   gdram_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .READ_REG(READ_REG)) u_mem (
      .clk(clk), .we(ram_we), .addr({page, col}), .wdata(cap_data),
      .rdata(ram_q)
   );

   always_comb begin
      status               = '0;
      status[STAT_OFF_BIT] = ~disp_on;
      status[STAT_RST_BIT] = host_rst;
   end

   assign db_oe  = bus_en & (&bus_cs) & bus_rd;
   assign db_out = bus_di ? ram_q : status;

   a_r9_no_write_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(&bus_cs));
   a_r6_status_rst_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (db_oe && !bus_di) |-> (db_out[STAT_RST_BIT] == host_rst));
endmodule

// File: tb/gdram_host_if_tb.sv
module gdram_host_if_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_rst = 1'b0;
   logic       bus_en = 1'b0, bus_rd = 1'b0, bus_di = 1'b0;
   logic [2:0] bus_cs = 3'b111;
   logic [7:0] db_in = 8'h00;
   logic [7:0] db_out;
   logic       db_oe, disp_on;
   logic [5:0] start_line;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gdram_host_if u_dut (
      .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .bus_en(bus_en),
      .bus_rd(bus_rd), .bus_di(bus_di), .bus_cs(bus_cs), .db_in(db_in),
      .db_out(db_out), .db_oe(db_oe), .disp_on(disp_on),
      .start_line(start_line)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic di, input logic rd, input logic [7:0] d,
                      output logic [7:0] q, output logic oe);
      @(negedge clk);
      bus_di = di; bus_rd = rd; db_in = d; bus_en = 1'b1;
      repeat (3) @(negedge clk);
      q = db_out; oe = db_oe;
      bus_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic di, input logic [7:0] d);
      logic [7:0] q; logic oe;
      cyc(di, 1'b0, d, q, oe);
   endtask

   task automatic rd(input logic di, output logic [7:0] q);
      logic oe;
      cyc(di, 1'b1, 8'h00, q, oe);
   endtask

   task automatic seek(input logic [2:0] p, input logic [5:0] c);
      wr(1'b0, {5'b10111, p});
      wr(1'b0, {2'b01, c});
   endtask

   task automatic t_reset();
      logic [7:0] q;
      check("R1 disp_on", disp_on, 0);
      check("R1 start_line", start_line, 0);
      check("R10 idle oe", db_oe, 0);
      rd(1'b0, q);
      check("R1 status", q, 8'h20);
   endtask

   task automatic t_write_read();
      logic [7:0] q;
      seek(3'd2, 6'd5);
      wr(1'b1, 8'hAA);
      wr(1'b1, 8'h55);
      seek(3'd2, 6'd5);
      rd(1'b1, q); check("R5 read first", q, 8'hAA);
      rd(1'b1, q); check("R2 write advance", q, 8'h55);
   endtask

   task automatic t_wrap();
      logic [7:0] q;
      seek(3'd2, 6'd0); wr(1'b1, 8'h77);
      seek(3'd1, 6'd62);
      wr(1'b1, 8'h11); wr(1'b1, 8'h22); wr(1'b1, 8'h33);
      seek(3'd1, 6'd63);
      rd(1'b1, q); check("R2 col63", q, 8'h22);
      rd(1'b1, q); check("R3 wrap to col0", q, 8'h33);
      seek(3'd2, 6'd0);
      rd(1'b1, q); check("R4 next page untouched", q, 8'h77);
   endtask

   task automatic t_onoff();
      logic [7:0] q;
      seek(3'd3, 6'd0); wr(1'b1, 8'h5A);
      wr(1'b0, 8'h3F);
      check("R7 on", disp_on, 1);
      rd(1'b0, q); check("R6 status on", q, 8'h00);
      wr(1'b0, 8'h3E);
      check("R7 off", disp_on, 0);
      rd(1'b0, q); check("R6 status off", q, 8'h20);
      seek(3'd3, 6'd0);
      rd(1'b1, q); check("R7 ram kept", q, 8'h5A);
   endtask

   task automatic t_start();
      wr(1'b0, 8'hC0 | 8'd17);
      check("R8 start line", start_line, 17);
   endtask

   task automatic t_cs();
      logic [7:0] q; logic oe;
      seek(3'd3, 6'd1); wr(1'b1, 8'h44);
      seek(3'd3, 6'd1);
      bus_cs = 3'b101;
      wr(1'b1, 8'hEE);
      wr(1'b0, 8'h3F);
      cyc(1'b1, 1'b1, 8'h00, q, oe);
      check("R9 oe unselected", oe, 0);
      bus_cs = 3'b111;
      check("R9 no instr", disp_on, 0);
      rd(1'b1, q); check("R9 no write", q, 8'h44);
   endtask

   task automatic t_oe();
      logic [7:0] q; logic oe;
      cyc(1'b0, 1'b0, 8'h00, q, oe);
      check("R10 oe on write", oe, 0);
      cyc(1'b0, 1'b1, 8'h00, q, oe);
      check("R10 oe on read", oe, 1);
      check("R10 oe after strobe", db_oe, 0);
   endtask

   task automatic t_host_rst();
      logic [7:0] q;
      wr(1'b0, 8'hC9); wr(1'b0, 8'h3F);
      host_rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R11 flag cleared", disp_on, 0);
      check("R11 start cleared", start_line, 0);
      rd(1'b0, q); check("R11 status", q, 8'h30);
      wr(1'b0, 8'h3F);
      check("R11 instr ignored", disp_on, 0);
      host_rst = 1'b0;
      rd(1'b0, q); check("R6 status after", q, 8'h20);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_wrap();
      t_onoff();
      t_start();
      t_cs();
      t_oe();
      t_host_rst();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule